// File: doc/BRIEF.md
# Chained DMA Channel Register Engine

This block is the control side of one DMA channel. Software sets it up through a 32-bit register port that holds a control/status word, a live transfer address, a live byte count, and a shadow address/count pair. The engine then moves data one burst at a time. Each burst is one handshake on a memory request/acknowledge interface and one on a device request/acknowledge interface. The order of the two handshakes depends on the transfer direction. The block carries no data; it only sequences the requests and keeps the bookkeeping registers up to date.

The shadow pair lets software queue the next buffer while the current one is still running. The address and count offsets are shared between the live and shadow registers. A steering bit in the control word decides which of the two a write lands in. When the byte count runs out with counting enabled, the engine raises terminal count and can raise an interrupt. If a shadow buffer is armed, the engine copies it into the live registers in the same cycle and keeps going with no idle gap visible to software.

The sequencer has six states:
- ST_IDLE waits for a start condition.
- ST_FETCH_MEM then ST_PUSH_DEV serve a memory-to-device burst.
- ST_PULL_DEV then ST_STORE_MEM serve a device-to-memory burst.
- ST_ADVANCE updates address and count for one cycle, then returns to ST_IDLE.

The transitions are:
- ST_IDLE leaves on start. It goes to ST_FETCH_MEM when the direction bit is 0 and to ST_PULL_DEV when it is 1.
- Each request state advances on its acknowledge.
- ST_ADVANCE always returns to ST_IDLE.

Top module: `dmach_engine`

## Requirements
- R1: After reset the control word (offset 0) reads 0xC000_0000, with the 4-bit ID 0xC in bits 31:28 and every other bit 0. The address (offset 4) and count (offset 8) read 0, and `irq` is 0.
- R2: When next-enable (control bit 24) is 1, writes to offsets 4 and 8 go to the shadow address and count. The live values are left unchanged and next-loaded (bit 27) is set. When bit 24 is 0, these writes go to the live registers and live-loaded (bit 26) is set. Count writes ignore bits 1:0.
- R3: The burst code in control bits 19:18 selects the words per burst shown on `mem_words`: 00 gives 4, 01 gives 8, 10 gives 1 and 11 gives 16.
- R4: With direction (bit 8) at 0, each burst is a memory read (`mem_wr`=0) followed by a device handshake. With bit 8 at 1, each burst is a device handshake followed by a memory write (`mem_wr`=1).
- R5: A transfer starts when DMA-enable (bit 9) is 1, bit 26 is 1, reset (bit 7) is 0, and, with count-enable (bit 13) set, the count is nonzero. Each burst advances the address by 4 bytes per word. With bit 13 set, each burst also lowers the count by the same amount. When fewer words remain than the burst size, single-word bursts finish the transfer.
- R6: When the count reaches 0 with bit 13 set, terminal count (bit 14) becomes 1 and the transfer stops unless R8 applies. Writing 1 to bit 14 clears it together with interrupt-pending (bit 0).
- R7: At terminal count, bit 0 is set unless TC-interrupt-off (bit 23) is 1. `irq` equals bit 0 AND interrupt-enable (bit 4).
- R8: At terminal count with bits 13 and 24 both set and bit 27 set, the live address and count are loaded from the shadow pair, bit 27 clears and the transfer continues. DMA-on (bit 25) stays 1 throughout.
- R9: With bit 13 clear the count is not changed, bursts are always full size, terminal count never occurs and the shadow pair is never loaded.
- R10: Writing 1 to bit 7 while it is 0 sets it and clears bits 14, 0, 26 and 27. No burst starts while bit 7 is 1. Writing 0 to bit 7 clears it only while cycle-pending (bit 10, which is 1 whenever the sequencer is not idle) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory burst request |
| mem_wr | output | 1 | 1 = burst writes memory, 0 = burst reads memory |
| mem_addr | output | 32 | Burst start address |
| mem_words | output | 5 | Words in this burst |
| mem_ack | input | 1 | Memory burst accepted |
| dev_req | output | 1 | Device burst request |
| dev_ack | input | 1 | Device burst accepted |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples `reg_wr`, so the bench reads it back at the next falling edge. Reads are combinational and are sampled 1 ns after a falling edge.

The first request appears one edge after the start condition holds in ST_IDLE. An acknowledge is consumed at the edge where it is high. Address, count, terminal count and reload change one edge after the last handshake of a burst, in ST_ADVANCE.

The bench drives acknowledges at falling edges with random delays and logs each accepted memory burst. It compares the log against a burst list it computes itself. It reads registers only after both request lines have been low for four cycles, which is long enough for ST_ADVANCE and the return to ST_IDLE to finish.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam logic [3:0] OFF_CSR  = 4'd0;
    localparam logic [3:0] OFF_ADDR = 4'd4;
    localparam logic [3:0] OFF_CNT  = 4'd8;

    localparam int unsigned B_INT_PEND  = 0;
    localparam int unsigned B_INT_EN    = 4;
    localparam int unsigned B_RESET     = 7;
    localparam int unsigned B_DIR       = 8;
    localparam int unsigned B_DMA_EN    = 9;
    localparam int unsigned B_CYC_PEND  = 10;
    localparam int unsigned B_CNT_EN    = 13;
    localparam int unsigned B_TC        = 14;
    localparam int unsigned B_BURST_LO  = 18;
    localparam int unsigned B_BURST_HI  = 19;
    localparam int unsigned B_TCI_OFF   = 23;
    localparam int unsigned B_NEXT_EN   = 24;
    localparam int unsigned B_DMA_ON    = 25;
    localparam int unsigned B_A_LOADED  = 26;
    localparam int unsigned B_NA_LOADED = 27;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_MEM,
        ST_PUSH_DEV,
        ST_PULL_DEV,
        ST_STORE_MEM,
        ST_ADVANCE
    } seq_state_e;

    typedef struct packed {
        logic       int_en;
        logic       reset_hold;
        logic       dir_to_mem;
        logic       dma_en;
        logic       cnt_en;
        logic [1:0] burst_code;
        logic       tc_irq_off;
        logic       next_en;
    } ctrl_t;

    function automatic logic [4:0] burst_words(input logic [1:0] code);
        logic [4:0] w;
        unique case (code)
            2'b00:   w = 5'd4;
            2'b01:   w = 5'd8;
            2'b10:   w = 5'd1;
            default: w = 5'd16;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned CNT_W   = 24,
    parameter logic [3:0]  ID_CODE = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        reg_off,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              busy,
    input  logic              dma_on,
    input  logic              adv,
    input  logic [CNT_W-1:0]  adv_bytes,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              a_loaded,
    output logic              irq
);

    localparam int unsigned LOW_BITS = 2;

    ctrl_t              ctrl_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  nxt_addr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   nxt_cnt_q;
    logic               tc_q;
    logic               int_pend_q;
    logic               a_loaded_q;
    logic               na_loaded_q;
    logic [CNT_W-1:0]   cnt_after;
    logic [CNT_W-1:0]   wr_cnt_val;
    logic               reload_now;
    logic [31:0]        csr_word;

    assign cnt_after  = cnt_q - adv_bytes;
    assign wr_cnt_val = {wr_data[CNT_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
    assign reload_now = ctrl_q.cnt_en && ctrl_q.next_en && na_loaded_q
                        && (cnt_after == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            addr_q      <= '0;
            nxt_addr_q  <= '0;
            cnt_q       <= '0;
            nxt_cnt_q   <= '0;
            tc_q        <= 1'b0;
            int_pend_q  <= 1'b0;
            a_loaded_q  <= 1'b0;
            na_loaded_q <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (reg_off)
                    OFF_CSR: begin
                        ctrl_q.int_en     <= wr_data[B_INT_EN];
                        ctrl_q.dir_to_mem <= wr_data[B_DIR];
                        ctrl_q.dma_en     <= wr_data[B_DMA_EN];
                        ctrl_q.cnt_en     <= wr_data[B_CNT_EN];
                        ctrl_q.burst_code <= wr_data[B_BURST_HI:B_BURST_LO];
                        ctrl_q.tc_irq_off <= wr_data[B_TCI_OFF];
                        ctrl_q.next_en    <= wr_data[B_NEXT_EN];
                        if (wr_data[B_TC]) begin
                            tc_q       <= 1'b0;
                            int_pend_q <= 1'b0;
                        end
                        if (wr_data[B_RESET]) begin
                            ctrl_q.reset_hold <= 1'b1;
                            if (!ctrl_q.reset_hold) begin
                                tc_q        <= 1'b0;
                                int_pend_q  <= 1'b0;
                                a_loaded_q  <= 1'b0;
                                na_loaded_q <= 1'b0;
                            end
                        end else if (!busy) begin
                            ctrl_q.reset_hold <= 1'b0;
                        end
                    end
                    OFF_ADDR: begin
                        if (ctrl_q.next_en) begin
                            nxt_addr_q  <= wr_data[ADDR_W-1:0];
                            na_loaded_q <= 1'b1;
                        end else begin
                            addr_q     <= wr_data[ADDR_W-1:0];
                            a_loaded_q <= 1'b1;
                        end
                    end
                    OFF_CNT: begin
                        if (ctrl_q.next_en) begin
                            nxt_cnt_q <= wr_cnt_val;
                        end else begin
                            cnt_q <= wr_cnt_val;
                        end
                    end
                    default: ;
                endcase
            end
            if (adv) begin
                addr_q <= addr_q + ADDR_W'(adv_bytes);
                if (ctrl_q.cnt_en) begin
                    cnt_q <= cnt_after;
                    if (cnt_after == '0) begin
                        tc_q <= 1'b1;
                        if (!ctrl_q.tc_irq_off) begin
                            int_pend_q <= 1'b1;
                        end
                    end
                    if (reload_now) begin
                        addr_q      <= nxt_addr_q;
                        cnt_q       <= nxt_cnt_q;
                        na_loaded_q <= 1'b0;
                        a_loaded_q  <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        csr_word              = '0;
        csr_word[31:28]       = ID_CODE;
        csr_word[B_INT_PEND]  = int_pend_q;
        csr_word[B_INT_EN]    = ctrl_q.int_en;
        csr_word[B_RESET]     = ctrl_q.reset_hold;
        csr_word[B_DIR]       = ctrl_q.dir_to_mem;
        csr_word[B_DMA_EN]    = ctrl_q.dma_en;
        csr_word[B_CYC_PEND]  = busy;
        csr_word[B_CNT_EN]    = ctrl_q.cnt_en;
        csr_word[B_TC]        = tc_q;
        csr_word[B_BURST_HI:B_BURST_LO] = ctrl_q.burst_code;
        csr_word[B_TCI_OFF]   = ctrl_q.tc_irq_off;
        csr_word[B_NEXT_EN]   = ctrl_q.next_en;
        csr_word[B_DMA_ON]    = dma_on;
        csr_word[B_A_LOADED]  = a_loaded_q;
        csr_word[B_NA_LOADED] = na_loaded_q;
    end

    always_comb begin
        unique case (reg_off)
            OFF_CSR:  rd_data = csr_word;
            OFF_ADDR: rd_data = 32'(addr_q);
            OFF_CNT:  rd_data = 32'(cnt_q);
            default:  rd_data = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign cur_addr = addr_q;
    assign cur_cnt  = cnt_q;
    assign a_loaded = a_loaded_q;
    assign irq      = int_pend_q & ctrl_q.int_en;

    // R8: an armed reload replaces the live pair and disarms the shadow
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && reload_now && !wr_en)
        |=> (!na_loaded_q && a_loaded_q && cnt_q == $past(nxt_cnt_q)
             && addr_q == $past(nxt_addr_q)));

    // R10: a zero written to the reset bit while a cycle is pending is ignored
    a_r10_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == OFF_CSR && !wr_data[B_RESET] && busy
         && ctrl_q.reset_hold) |=> ctrl_q.reset_hold);

    // R6: writing one to terminal count clears it when no burst completes
    a_r6_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_off == OFF_CSR && wr_data[B_TC] && !adv) |=> !tc_q);

    // R7: interrupt pending never stands without terminal count
    a_r7_pend_has_tc: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend_q |-> tc_q);

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic             a_loaded,
    input  logic             mem_ack,
    input  logic             dev_ack,
    output logic             mem_req,
    output logic             mem_wr,
    output logic [4:0]       mem_words,
    output logic             dev_req,
    output logic             adv,
    output logic [CNT_W-1:0] adv_bytes,
    output logic             busy,
    output logic             dma_on
);

    localparam int unsigned WORD_W = CNT_W - 2;

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [4:0]        words_q;
    logic [4:0]        full_words;
    logic [4:0]        pick_words;
    logic [WORD_W-1:0] cnt_words;
    logic              go;

    assign cnt_words  = cur_cnt[CNT_W-1:2];
    assign full_words = burst_words(ctrl.burst_code);
    assign pick_words = (ctrl.cnt_en && (cnt_words < WORD_W'(full_words)))
                        ? 5'd1 : full_words;
    assign go = ctrl.dma_en && !ctrl.reset_hold && a_loaded
                && (!ctrl.cnt_en || (cnt_words != '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            words_q <= 5'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go) begin
                words_q <= pick_words;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go) state_d = ctrl.dir_to_mem ? ST_PULL_DEV : ST_FETCH_MEM;
            ST_FETCH_MEM: if (mem_ack) state_d = ST_PUSH_DEV;
            ST_PUSH_DEV:  if (dev_ack) state_d = ST_ADVANCE;
            ST_PULL_DEV:  if (dev_ack) state_d = ST_STORE_MEM;
            ST_STORE_MEM: if (mem_ack) state_d = ST_ADVANCE;
            ST_ADVANCE:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        mem_wr  = 1'b0;
        dev_req = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            ST_FETCH_MEM: mem_req = 1'b1;
            ST_STORE_MEM: begin
                mem_req = 1'b1;
                mem_wr  = 1'b1;
            end
            ST_PUSH_DEV,
            ST_PULL_DEV:  dev_req = 1'b1;
            ST_ADVANCE:   adv = 1'b1;
            default: ;
        endcase
    end

    assign mem_words = words_q;
    assign adv_bytes = CNT_W'({words_q, 2'b00});
    assign busy      = (state_q != ST_IDLE);
    assign dma_on    = busy || go;

    // R10: no burst leaves idle while the reset bit is held
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctrl.reset_hold) |=> (state_q == ST_IDLE));

    // R3: only the four encoded burst lengths reach the memory side
    a_r3_words_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_words inside {5'd1, 5'd4, 5'd8, 5'd16}));

    // R5: a counted burst never exceeds the words still owed
    a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ctrl.cnt_en) |-> (WORD_W'(words_q) <= cnt_words));

    // R4: a device push is only reached through a memory fetch
    a_r4_push_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_DEV)
        |-> ($past(state_q) == ST_FETCH_MEM || $past(state_q) == ST_PUSH_DEV));

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned CNT_W   = 24,
    parameter logic [3:0]  ID_CODE = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [4:0]        mem_words,
    input  logic              mem_ack,
    output logic              dev_req,
    input  logic              dev_ack,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [CNT_W-1:0]  cur_cnt;
    logic [CNT_W-1:0]  adv_bytes;
    logic              a_loaded;
    logic              adv;
    logic              busy;
    logic              dma_on;

    dmach_regs #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .ID_CODE (ID_CODE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .reg_off   (reg_addr),
        .wr_data   (reg_wdata),
        .rd_data   (reg_rdata),
        .busy      (busy),
        .dma_on    (dma_on),
        .adv       (adv),
        .adv_bytes (adv_bytes),
        .ctrl      (ctrl),
        .cur_addr  (mem_addr),
        .cur_cnt   (cur_cnt),
        .a_loaded  (a_loaded),
        .irq       (irq)
    );

    dmach_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .cur_cnt   (cur_cnt),
        .a_loaded  (a_loaded),
        .mem_ack   (mem_ack),
        .dev_ack   (dev_ack),
        .mem_req   (mem_req),
        .mem_wr    (mem_wr),
        .mem_words (mem_words),
        .dev_req   (dev_req),
        .adv       (adv),
        .adv_bytes (adv_bytes),
        .busy      (busy),
        .dma_on    (dma_on)
    );

endmodule

// File: tb/test_dmach_engine.sv
module test_dmach_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_wr, dev_req, irq;
    logic [31:0] mem_addr;
    logic [4:0]  mem_words;
    logic        mem_ack = 1'b0;
    logic        dev_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [31:0] log_addr [64];
    logic [4:0]  log_words [64];
    logic        log_wr [64];
    int          log_n = 0;
    logic [31:0] exp_addr [64];
    logic [4:0]  exp_words [64];
    int          exp_n = 0;
    int          mem_cnt = 0, dev_cnt = 0, ord_bad = 0, on_gaps = 0;
    bit          hold = 1'b0;
    bit          cur_dir = 1'b0;
    bit          mon_on = 1'b0;

    always #4 clk = ~clk;

    dmach_engine i_dmach_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_words(mem_words),
        .mem_ack(mem_ack), .dev_req(dev_req), .dev_ack(dev_ack), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] csr(bit en, bit dir, bit cnt, bit nxt, bit ie,
                                        bit tcioff, logic [1:0] code, bit rst, bit tcclr);
        logic [31:0] v = '0;
        v[9] = en; v[8] = dir; v[13] = cnt; v[24] = nxt; v[4] = ie;
        v[23] = tcioff; v[19:18] = code; v[7] = rst; v[14] = tcclr;
        return v;
    endfunction

    function automatic int code_words(logic [1:0] code);
        case (code)
            2'b00: return 4;
            2'b01: return 8;
            2'b10: return 1;
            default: return 16;
        endcase
    endfunction

    task automatic wr(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'd0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_addr = off;
        #1 d = reg_rdata;
        reg_addr = 4'd0;
    endtask

    task automatic clear_log();
        log_n = 0; exp_n = 0; mem_cnt = 0; dev_cnt = 0; ord_bad = 0; on_gaps = 0;
    endtask

    task automatic model(input logic [31:0] a, input int bytes, input logic [1:0] code);
        int words = bytes / 4;
        int bw = code_words(code);
        while (words > 0) begin
            int n = (words < bw) ? 1 : bw;
            exp_addr[exp_n] = a; exp_words[exp_n] = 5'(n); exp_n++;
            a += 32'(4 * n); words -= n;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (!(log_n >= exp_n && !mem_req && !dev_req) && guard < 20000) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(input string req, input bit dir);
        chk({req, " burst count"}, 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk({req, " burst addr"}, log_addr[i], exp_addr[i]);
            chk({req, " burst words (R3)"}, 32'(log_words[i]), 32'(exp_words[i]));
            chk({req, " direction (R4)"}, 32'(log_wr[i]), 32'(dir));
        end
        chk({req, " handshake order (R4)"}, 32'(ord_bad), 32'd0);
    endtask

    // responder: random-delay acknowledges, burst log, order check
    initial begin
        void'($urandom(32'd20240611));
        forever begin
            @(negedge clk);
            mem_ack = 1'b0; dev_ack = 1'b0;
            if (!hold && mem_req && ($urandom_range(2) == 0)) begin
                mem_ack = 1'b1;
                if (log_n < 64) begin
                    log_addr[log_n] = mem_addr; log_words[log_n] = mem_words;
                    log_wr[log_n] = mem_wr;
                end
                log_n++;
                if (cur_dir && dev_cnt != mem_cnt + 1) ord_bad++;
                mem_cnt++;
            end
            if (!hold && dev_req && ($urandom_range(2) == 0)) begin
                dev_ack = 1'b1;
                if (!cur_dir && mem_cnt != dev_cnt + 1) ord_bad++;
                dev_cnt++;
            end
            if (mon_on && reg_addr == 4'd0 && !reg_wr && log_n > 0 && log_n < exp_n
                && !reg_rdata[25]) on_gaps++;
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(4'd0, v); chk("R1 csr reset", v, 32'hC000_0000);
        rd(4'd4, v); chk("R1 addr reset", v, 32'd0);
        rd(4'd8, v); chk("R1 count reset", v, 32'd0);
        chk("R1 irq reset", 32'(irq), 32'd0);

        // R5/R6/R7: 10 words, burst 4, memory to device, interrupt on
        clear_log(); cur_dir = 1'b0;
        wr(4'd4, 32'h0000_1000);
        wr(4'd8, 32'd40);
        model(32'h0000_1000, 40, 2'b00);
        wr(4'd0, csr(1, 0, 1, 0, 1, 0, 2'b00, 0, 0));
        wait_idle();
        compare("R5 clip", 1'b0);
        rd(4'd4, v); chk("R5 addr after", v, 32'h0000_1028);
        rd(4'd8, v); chk("R5 count after", v, 32'd0);
        rd(4'd0, v);
        chk("R6 tc set", 32'(v[14]), 32'd1);
        chk("R7 pend set", 32'(v[0]), 32'd1);
        chk("R10 cyc pend idle", 32'(v[10]), 32'd0);
        chk("R7 irq high", 32'(irq), 32'd1);
        wr(4'd0, csr(0, 0, 1, 0, 1, 0, 2'b00, 0, 1));
        rd(4'd0, v);
        chk("R6 tc cleared", 32'(v[14]), 32'd0);
        chk("R6 pend cleared", 32'(v[0]), 32'd0);
        chk("R7 irq low", 32'(irq), 32'd0);

        // R7: terminal-count interrupt suppressed, device to memory, burst 8
        clear_log(); cur_dir = 1'b1;
        wr(4'd4, 32'h0000_2000);
        wr(4'd8, 32'd32);
        model(32'h0000_2000, 32, 2'b01);
        wr(4'd0, csr(1, 1, 1, 0, 1, 1, 2'b01, 0, 0));
        wait_idle();
        compare("R4 dev2mem", 1'b1);
        rd(4'd0, v);
        chk("R7 tc with off", 32'(v[14]), 32'd1);
        chk("R7 no pend with off", 32'(v[0]), 32'd0);
        chk("R7 no irq with off", 32'(irq), 32'd0);

        // R3/R4/R5 random runs
        for (int it = 0; it < 8; it++) begin
            logic [1:0]  code = 2'($urandom_range(3));
            bit          dir = 1'($urandom_range(1));
            int          bytes = 4 * int'($urandom_range(40, 1));
            logic [31:0] base = {16'h0010, 4'($urandom_range(15)), 12'h000};
            wr(4'd0, csr(0, dir, 1, 0, 0, 0, code, 0, 1));
            clear_log(); cur_dir = dir;
            wr(4'd4, base);
            wr(4'd8, 32'(bytes));
            model(base, bytes, code);
            wr(4'd0, csr(1, dir, 1, 0, 0, 0, code, 0, 0));
            wait_idle();
            compare("R3 random", dir);
            rd(4'd4, v); chk("R5 random addr", v, base + 32'(bytes));
        end

        // R2/R8 chained buffers
        wr(4'd0, csr(0, 0, 1, 0, 0, 0, 2'b11, 0, 1));
        clear_log(); cur_dir = 1'b0;
        wr(4'd4, 32'h0000_3000);
        wr(4'd8, 32'd160);
        wr(4'd0, csr(0, 0, 1, 1, 0, 0, 2'b11, 0, 0));
        wr(4'd4, 32'h0000_7000);
        wr(4'd8, 32'd83);
        rd(4'd4, v); chk("R2 live addr kept", v, 32'h0000_3000);
        rd(4'd8, v); chk("R2 live count kept", v, 32'd160);
        rd(4'd0, v);
        chk("R2 next loaded", 32'(v[27]), 32'd1);
        chk("R2 live loaded", 32'(v[26]), 32'd1);
        model(32'h0000_3000, 160, 2'b11);
        model(32'h0000_7000, 80, 2'b11);
        mon_on = 1'b1;
        wr(4'd0, csr(1, 0, 1, 1, 0, 0, 2'b11, 0, 0));
        wait_idle();
        mon_on = 1'b0;
        compare("R8 chain", 1'b0);
        chk("R8 dma on held", 32'(on_gaps), 32'd0);
        rd(4'd4, v); chk("R8 addr after", v, 32'h0000_7050);
        rd(4'd0, v);
        chk("R8 next loaded cleared", 32'(v[27]), 32'd0);
        chk("R8 tc at end", 32'(v[14]), 32'd1);

        // R9 counter disabled: no count, no clip, no reload
        wr(4'd0, csr(0, 0, 0, 0, 0, 0, 2'b00, 0, 1));
        clear_log(); cur_dir = 1'b0;
        wr(4'd4, 32'h0000_8000);
        wr(4'd8, 32'd8);
        wr(4'd0, csr(0, 0, 0, 1, 0, 0, 2'b00, 0, 0));
        wr(4'd4, 32'h0000_9000);
        wr(4'd8, 32'd16);
        wr(4'd0, csr(1, 0, 0, 1, 0, 0, 2'b00, 0, 0));
        while (log_n < 5) @(negedge clk);
        wr(4'd0, csr(0, 0, 0, 1, 0, 0, 2'b00, 0, 0));
        exp_n = 0;
        wait_idle();
        for (int i = 0; i < log_n && i < 64; i++) begin
            chk("R9 full burst", 32'(log_words[i]), 32'd4);
            chk("R9 addr step", log_addr[i], 32'h0000_8000 + 32'(16 * i));
        end
        rd(4'd4, v); chk("R9 addr no reload", v, 32'h0000_8000 + 32'(16 * log_n));
        rd(4'd8, v); chk("R9 count unchanged", v, 32'd8);
        rd(4'd0, v);
        chk("R9 no tc", 32'(v[14]), 32'd0);
        chk("R9 next still loaded", 32'(v[27]), 32'd1);

        // R10 reset bit
        wr(4'd0, csr(0, 0, 1, 0, 0, 0, 2'b10, 0, 1));
        clear_log(); cur_dir = 1'b0;
        wr(4'd4, 32'h0000_4000);
        wr(4'd8, 32'd8);
        hold = 1'b1;
        wr(4'd0, csr(1, 0, 1, 0, 0, 0, 2'b10, 0, 0));
        while (!mem_req) @(negedge clk);
        wr(4'd0, csr(1, 0, 1, 0, 0, 0, 2'b10, 1, 0));
        wr(4'd0, csr(1, 0, 1, 0, 0, 0, 2'b10, 0, 0));
        rd(4'd0, v);
        chk("R10 reset kept while pending", 32'(v[7]), 32'd1);
        chk("R10 cyc pend set", 32'(v[10]), 32'd1);
        chk("R10 live loaded cleared", 32'(v[26]), 32'd0);
        hold = 1'b0;
        exp_n = 1;
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R10 one burst only", 32'(log_n), 32'd1);
        wr(4'd4, 32'h0000_5000);
        wr(4'd0, csr(1, 0, 1, 0, 0, 0, 2'b10, 1, 0));
        repeat (20) @(negedge clk);
        chk("R10 no start in reset", 32'(log_n), 32'd1);
        rd(4'd0, v);
        chk("R10 live loaded kept", 32'(v[26]), 32'd1);
        clear_log();
        model(32'h0000_5000, 4, 2'b10);
        wr(4'd0, csr(1, 0, 1, 0, 0, 0, 2'b10, 0, 0));
        wait_idle();
        compare("R10 resume", 1'b0);
        rd(4'd0, v); chk("R10 reset cleared", 32'(v[7]), 32'd0);
        chk("R1 id field", 32'(v[31:28]), 32'hC);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule